// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block sets the update mode of the fetch, decode and execute pipeline registers in a five-stage in-order pipeline. The five stages are fetch, decode, execute, memory and write-back. The block reads the operation codes held in the decode, execute and memory registers, plus a few fields that go with them:

- the two source register IDs of the instruction in decode;
- the memory-result destination of the instruction in execute;
- the branch-taken flag that execute computes.

From these it raises stall and bubble controls. The pipeline registers apply those controls at the next rising clock edge.

The block handles three hazard classes:

- A load or pop in execute that feeds the instruction in decode. The block holds fetch and decode for one cycle and puts a bubble into execute.
- A conditional jump in execute that turns out not-taken, when the pipeline predicts every jump taken. The block flushes the two target instructions that were fetched after the jump.
- A return anywhere in decode, execute or memory. The block freezes fetch and fills decode with bubbles until the return reaches write-back.

When a load-use hazard and a return fall in the same cycle, the load-use hazard wins. Decode is then held rather than flushed, so the return stays in decode for one more cycle.

The control outputs are purely combinational. A small wrapper stage records, at each clock edge, the mode that each of the three pipeline registers takes. Each recorder is a three-state machine:

| State | Encoding | Entered when |
|---|---|---|
| MODE_RUN | 0 | neither control is asserted |
| MODE_HOLD | 1 | stall is asserted |
| MODE_FLUSH | 2 | bubble is asserted |

The next state depends only on the two controls sampled at that edge, so any state can move to any other. Reset puts every recorder in MODE_RUN.

Top module: `hz_ctrl_unit`

## Requirements
- R1: The instruction in execute may be a load (code 4'h5) or a pop (code 4'hB). If its memory destination equals a decode source register that is not 4'h8, f_stall, d_stall and e_bubble are all 1 in that cycle. In this case d_bubble is 0.
- R2: A decode source equal to 4'h8 means "no register" and never matches. This holds even when the execute destination is also 4'h8.
- R3: When execute holds a conditional jump (code 4'h7) and e_taken is 0, d_bubble and e_bubble are both 1. When e_taken is 1 for that jump, neither is raised by the jump.
- R4: When a return (code 4'h9) is in decode, execute or memory, f_stall and d_bubble are 1, provided no load-use hazard is present.
- R5: When a load-use hazard and a return are present together, d_stall is 1, d_bubble is 0, and f_stall and e_bubble are 1.
- R6: A not-taken jump in execute together with a return in decode gives d_bubble=1, e_bubble=1, d_stall=0 and f_stall=1.
- R7: With none of the above present, all four controls are 0. Calls (code 4'h8) and every other code count as ordinary operations.
- R8: d_stall and d_bubble are never 1 at the same time.
- R9: At each rising edge, f_mode_q, d_mode_q and e_mode_q take the mode their register applies: 0 for run, 1 for stall, 2 for bubble. All three are 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the mode recorders |
| d_icode | input | 4 | Operation code in the decode register |
| e_icode | input | 4 | Operation code in the execute register |
| m_icode | input | 4 | Operation code in the memory register |
| d_src_a | input | 4 | First decode source register ID |
| d_src_b | input | 4 | Second decode source register ID |
| e_dst_m | input | 4 | Memory-result destination of the execute instruction |
| e_taken | input | 1 | Branch condition outcome computed in execute |
| f_stall | output | 1 | Hold the fetch register |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Load a bubble into the decode register |
| e_bubble | output | 1 | Load a bubble into the execute register |
| f_mode_q | output | 2 | Mode taken by fetch at the last edge |
| d_mode_q | output | 2 | Mode taken by decode at the last edge |
| e_mode_q | output | 2 | Mode taken by execute at the last edge |

## Verification
A wrong hazard class or a wrong priority appears on the four control outputs in the same cycle as the stimulus, so every input pattern is judged within that cycle. A mode recorder stuck in the wrong state, or decoding the wrong control, shows on its mode port one edge later. The bench therefore checks each recorder at the cycle after every stimulus. The hardest case is the load-use plus return overlap, where an error shows as decode flushed instead of held.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int ICODE_W   = 4;
    localparam int REG_W     = 4;
    localparam int NUM_SRC   = 2;
    localparam int NUM_RSTG  = 3;
    localparam int MODE_W    = 2;

    localparam logic [REG_W-1:0]   NO_REG  = 4'h8;
    localparam logic [ICODE_W-1:0] OP_LOAD = 4'h5;
    localparam logic [ICODE_W-1:0] OP_JCC  = 4'h7;
    localparam logic [ICODE_W-1:0] OP_CALL = 4'h8;
    localparam logic [ICODE_W-1:0] OP_RET  = 4'h9;
    localparam logic [ICODE_W-1:0] OP_POP  = 4'hB;

    typedef enum logic [MODE_W-1:0] {
        MODE_RUN   = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_FLUSH = 2'd2
    } mode_t;

    function automatic logic reads_memory(input logic [ICODE_W-1:0] code);
        return (code == OP_LOAD) || (code == OP_POP);
    endfunction
endpackage

// File: rtl/hz_loaduse_det.sv
module hz_loaduse_det
    import hz_pkg::*;
(
    input  logic [ICODE_W-1:0] e_icode_i,
    input  logic [REG_W-1:0]   e_dst_i,
    input  logic [REG_W-1:0]   src_i [NUM_SRC],
    output logic               hit_o
);
    logic [NUM_SRC-1:0] match;
    logic               is_ld;

    assign is_ld = reads_memory(e_icode_i);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign match[g] = (src_i[g] != NO_REG) && (src_i[g] == e_dst_i);
    end

    assign hit_o = is_ld && (|match);
endmodule

// File: rtl/hz_ret_det.sv
module hz_ret_det
    import hz_pkg::*;
(
    input  logic [ICODE_W-1:0] code_i [NUM_RSTG],
    output logic               hit_o
);
    logic [NUM_RSTG-1:0] in_stage;

    for (genvar g = 0; g < NUM_RSTG; g++) begin : g_stg
        assign in_stage[g] = (code_i[g] == OP_RET);
    end

    assign hit_o = |in_stage;
endmodule

// File: rtl/hz_branch_det.sv
module hz_branch_det
    import hz_pkg::*;
(
    input  logic [ICODE_W-1:0] e_icode_i,
    input  logic               taken_i,
    output logic               miss_o
);
    assign miss_o = (e_icode_i == OP_JCC) && !taken_i;
endmodule

// File: rtl/hz_arbiter.sv
module hz_arbiter (
    input  logic lu_i,
    input  logic miss_i,
    input  logic ret_i,
    output logic f_stall_o,
    output logic d_stall_o,
    output logic d_bubble_o,
    output logic e_bubble_o
);
    always_comb begin
        f_stall_o  = lu_i || ret_i;
        d_stall_o  = lu_i;
        // load-use outranks the return flush of decode
        d_bubble_o = miss_i || (ret_i && !lu_i);
        e_bubble_o = miss_i || lu_i;
    end
endmodule

// File: rtl/hz_mode_reg.sv
module hz_mode_reg
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              flush_i,
    output logic [MODE_W-1:0] mode_o
);
    mode_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case ({hold_i, flush_i})
            2'b00:   state_d = MODE_RUN;
            2'b10:   state_d = MODE_HOLD;
            2'b01:   state_d = MODE_FLUSH;
            default: state_d = MODE_FLUSH;
        endcase
    end

    always_comb begin
        mode_o = state_q;
    end
endmodule

// File: rtl/hz_ctrl_unit.sv
module hz_ctrl_unit
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        d_icode,
    input  logic [3:0]        e_icode,
    input  logic [3:0]        m_icode,
    input  logic [3:0]        d_src_a,
    input  logic [3:0]        d_src_b,
    input  logic [3:0]        e_dst_m,
    input  logic              e_taken,
    output logic              f_stall,
    output logic              d_stall,
    output logic              d_bubble,
    output logic              e_bubble,
    output logic [1:0]        f_mode_q,
    output logic [1:0]        d_mode_q,
    output logic [1:0]        e_mode_q
);
    logic [REG_W-1:0]   srcs  [NUM_SRC];
    logic [ICODE_W-1:0] codes [NUM_RSTG];
    logic lu_hit, ret_hit, br_miss;

    assign srcs[0]  = d_src_a;
    assign srcs[1]  = d_src_b;
    assign codes[0] = d_icode;
    assign codes[1] = e_icode;
    assign codes[2] = m_icode;

    hz_loaduse_det i_lu (
        .e_icode_i (e_icode),
        .e_dst_i   (e_dst_m),
        .src_i     (srcs),
        .hit_o     (lu_hit)
    );

    hz_ret_det i_ret (
        .code_i (codes),
        .hit_o  (ret_hit)
    );

    hz_branch_det i_br (
        .e_icode_i (e_icode),
        .taken_i   (e_taken),
        .miss_o    (br_miss)
    );

    hz_arbiter i_arb (
        .lu_i       (lu_hit),
        .miss_i     (br_miss),
        .ret_i      (ret_hit),
        .f_stall_o  (f_stall),
        .d_stall_o  (d_stall),
        .d_bubble_o (d_bubble),
        .e_bubble_o (e_bubble)
    );

    hz_mode_reg i_fmode (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (f_stall),
        .flush_i (1'b0),
        .mode_o  (f_mode_q)
    );

    hz_mode_reg i_dmode (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (d_stall),
        .flush_i (d_bubble),
        .mode_o  (d_mode_q)
    );

    hz_mode_reg i_emode (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (1'b0),
        .flush_i (e_bubble),
        .mode_o  (e_mode_q)
    );
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk
    import hz_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] d_icode,
    input logic [3:0] e_icode,
    input logic [3:0] m_icode,
    input logic [3:0] d_src_a,
    input logic [3:0] d_src_b,
    input logic [3:0] e_dst_m,
    input logic       e_taken,
    input logic       f_stall,
    input logic       d_stall,
    input logic       d_bubble,
    input logic       e_bubble,
    input logic [1:0] f_mode_q,
    input logic [1:0] d_mode_q,
    input logic [1:0] e_mode_q
);
    logic ld_e, dep, any_ret, miss;
    assign ld_e    = (e_icode == OP_LOAD) || (e_icode == OP_POP);
    assign dep     = ((d_src_a != NO_REG) && (d_src_a == e_dst_m)) ||
                     ((d_src_b != NO_REG) && (d_src_b == e_dst_m));
    assign any_ret = (d_icode == OP_RET) || (e_icode == OP_RET) || (m_icode == OP_RET);
    assign miss    = (e_icode == OP_JCC) && !e_taken;

    AST_LOADUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_e && dep) |-> (f_stall && d_stall && e_bubble && !d_bubble)); // R1
    AST_NOREG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (d_src_a == NO_REG && d_src_b == NO_REG) |-> !d_stall); // R2
    AST_MISPREDICT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (d_bubble && e_bubble)); // R3
    AST_RET_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (any_ret && !(ld_e && dep)) |-> (f_stall && d_bubble)); // R4
    AST_LU_OVER_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (any_ret && ld_e && dep) |-> (d_stall && !d_bubble)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ret && !miss && !(ld_e && dep)) |-> !(f_stall || d_stall || d_bubble || e_bubble)); // R7
    AST_D_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(d_stall && d_bubble)); // R8
    AST_DMODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        d_stall |=> (d_mode_q == 2'd1)); // R9
    AST_EMODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        e_bubble |=> (e_mode_q == 2'd2)); // R9
    AST_FMODE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !f_stall |=> (f_mode_q == 2'd0)); // R9
endmodule

bind hz_ctrl_unit hz_ctrl_chk i_chk (.*);

// File: tb/test_hz_ctrl_unit.sv
module test_hz_ctrl_unit;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] d_icode = 4'h0, e_icode = 4'h0, m_icode = 4'h0;
    logic [3:0] d_src_a = 4'h8, d_src_b = 4'h8, e_dst_m = 4'h8;
    logic e_taken = 1'b0;
    logic f_stall, d_stall, d_bubble, e_bubble;
    logic [1:0] f_mode_q, d_mode_q, e_mode_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hz_ctrl_unit i_hz_ctrl_unit (.*);

    function automatic logic [3:0] model(input logic [3:0] dc, ec, mc, sa, sb, dm,
                                         input logic tk);
        logic lu, ms, rt;
        lu = (ec == 4'h5 || ec == 4'hB) &&
             ((sa != 4'h8 && sa == dm) || (sb != 4'h8 && sb == dm));
        ms = (ec == 4'h7) && !tk;
        rt = (dc == 4'h9) || (ec == 4'h9) || (mc == 4'h9);
        return {lu || rt, lu, ms || (rt && !lu), ms || lu};
    endfunction

    function automatic logic [1:0] mode_of(input logic st, input logic bb);
        return bb ? 2'd2 : (st ? 2'd1 : 2'd0);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [3:0] dc, ec, mc, sa, sb, dm,
                         input logic tk);
        logic [3:0] e;
        d_icode = dc; e_icode = ec; m_icode = mc;
        d_src_a = sa; d_src_b = sb; e_dst_m = dm; e_taken = tk;
        e = model(dc, ec, mc, sa, sb, dm, tk);
        @(negedge clk);
        check(tag, {28'd0, f_stall, d_stall, d_bubble, e_bubble}, {28'd0, e});
        @(posedge clk);
        #1;
        check("R9 fetch mode", {30'd0, f_mode_q}, {30'd0, mode_of(e[3], 1'b0)});
        check("R9 decode mode", {30'd0, d_mode_q}, {30'd0, mode_of(e[2], e[1])});
        check("R9 execute mode", {30'd0, e_mode_q}, {30'd0, mode_of(1'b0, e[0])});
    endtask

    function automatic logic [3:0] pick_code();
        case ($urandom % 8)
            0: return 4'h5;
            1: return 4'hB;
            2: return 4'h7;
            3: return 4'h9;
            4: return 4'h8;
            default: return 4'($urandom);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset fetch", {30'd0, f_mode_q}, 32'd0);
        check("R9 reset decode", {30'd0, d_mode_q}, 32'd0);
        check("R9 reset execute", {30'd0, e_mode_q}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        apply("R7 idle", 4'h0, 4'h0, 4'h0, 4'h1, 4'h2, 4'h8, 1'b0);
        apply("R1 load via src a", 4'h0, 4'h5, 4'h0, 4'h3, 4'h8, 4'h3, 1'b0);
        apply("R1 pop via src b", 4'h0, 4'hB, 4'h0, 4'h8, 4'h6, 4'h6, 1'b0);
        apply("R1 load no dependence", 4'h0, 4'h5, 4'h0, 4'h1, 4'h2, 4'h3, 1'b0);
        apply("R2 no-register sources", 4'h0, 4'h5, 4'h0, 4'h8, 4'h8, 4'h8, 1'b0);
        apply("R3 not-taken jump", 4'h0, 4'h7, 4'h0, 4'h1, 4'h2, 4'h8, 1'b0);
        apply("R3 taken jump", 4'h0, 4'h7, 4'h0, 4'h1, 4'h2, 4'h8, 1'b1);
        apply("R4 return in decode", 4'h9, 4'h0, 4'h0, 4'h4, 4'h8, 4'h8, 1'b0);
        apply("R4 return in execute", 4'h0, 4'h9, 4'h0, 4'h4, 4'h8, 4'h8, 1'b0);
        apply("R4 return in memory", 4'h0, 4'h0, 4'h9, 4'h4, 4'h8, 4'h8, 1'b0);
        apply("R5 load-use with return", 4'h9, 4'h5, 4'h0, 4'h4, 4'h4, 4'h4, 1'b0);
        apply("R5 pop-use with return", 4'h9, 4'hB, 4'h0, 4'h8, 4'h4, 4'h4, 1'b0);
        apply("R6 mispredict with return", 4'h9, 4'h7, 4'h0, 4'h4, 4'h8, 4'h4, 1'b0);
        apply("R7 call ordinary", 4'h8, 4'h8, 4'h8, 4'h1, 4'h2, 4'h1, 1'b0);
        apply("R8 no dual decode control", 4'h9, 4'h5, 4'h9, 4'h2, 4'h8, 4'h2, 1'b0);
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] dc, ec, mc, sa, sb, dm;
            logic tk;
            dc = pick_code(); ec = pick_code(); mc = pick_code();
            sa = 4'($urandom % 10); sb = 4'($urandom % 10); dm = 4'($urandom % 10);
            tk = 1'($urandom);
            apply("R1 R3 R4 R5 R8 random", dc, ec, mc, sa, sb, dm, tk);
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule